// File: doc/BRIEF.md
# Pipelined Ring-Carry Ones-Complement Accumulator

The block sums a stream of 32-bit words into two 16-bit ones-complement partial sums held side by side in one output register. The lower half of the register collects the low half-words of the stream and the upper half collects the high half-words. Each word passes through a one-word input latch and is absorbed into the sum register in a single clock with one level of logic. That makes the block suitable for summing a data transfer at full bus rate.

Each 16-bit lane is built as a ring of six short full-lookahead adder groups, with widths 3, 3, 2, 3, 3, 2 from the low bit upward. The carry out of a group goes into a one-bit register, and that register feeds the carry-in of the next group up on the following clock. The carry register of the top group feeds the bottom group of the same lane, which gives the end-around carry. Carries therefore keep moving around the ring for a few clocks after the last word. A `settled` flag tells the consumer when the register holds the final partial sums. The consumer then adds the two halves in ones-complement arithmetic and inverts the result to obtain the Internet checksum.

Top module: `oc_ring_accum`

## Requirements
- R1: Bits 15..0 of `sum_q` accumulate bits 15..0 of each accepted word, and bits 31..16 accumulate bits 31..16. No carry ever passes from one lane into the other.
- R2: Once settled, each lane equals the ones-complement sum of its accepted half-words: a 16-bit end-around-carry sum starting from 0, so 0xFFFF plus 0x0001 gives 0x0001.
- R3: A word presented with `add_en` high at a rising edge is accepted. Words can be accepted on every consecutive clock. `settled` is low on the cycle after an accepting edge.
- R4: A word presented with `add_en` low is ignored and zero is added in its place. A settled sum stays settled and unchanged while `add_en` stays low.
- R5: After the last accepting edge, `settled` is high no later than 8 rising edges later. All pending carries have drained by then.
- R6: `settled` is high exactly when the input latch is empty and all twelve carry registers are zero. While it is high and `clr` is low, `sum_q` keeps its value on the next edge.
- R7: `clr` high at an edge zeroes the sum register, the carry registers and the input latch. A word presented with `add_en` high at that same edge is discarded, because clear has priority. On the next cycle `sum_q` is 0 and `settled` is 1.
- R8: `rst_n` low at an edge has the same effect as `clr`. It is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of sum, carries and latch; priority over add_en |
| add_en | input | 1 | Accept `din` at this edge |
| din | input | 32 | Data word to accumulate |
| sum_q | output | 32 | Two 16-bit ones-complement partial sums {high lane, low lane} |
| settled | output | 1 | No carry pending and latch empty; `sum_q` is final |

## Verification
The bench targets the carry chain that wraps all the way around a lane. A lane at 0xFFFF receives +1 and must ripple through all six groups before it reads 0x0001. A broken end-around link would leave 0x0000, and a short drain bound would raise `settled` too early. Overflow is driven into the low lane while the high lane stays at zero, so any leak across the lane boundary shows up as a non-zero upper half. Clear is asserted together with `add_en` to confirm that the word is dropped. Long bursts with and without gaps are folded and inverted, then compared with an independently computed Internet checksum; a lost or duplicated word in the one-per-clock path would change that checksum.

// File: rtl/oc_accum_pkg.sv
// Package: group layout of the ring adder, computed from the lane width.
// Assumes the lane width is a multiple of 8; each 8-bit slice is split 3,3,2.
package oc_accum_pkg;

    // Number of lookahead groups in one lane
    function automatic int grp_count(input int lane_w);
        return (lane_w / 8) * 3;
    endfunction

    // Lowest bit of group g within its lane
    function automatic int grp_lsb(input int g);
        return (g / 3) * 8 + (g % 3) * 3;
    endfunction

    // Width of group g (pattern 3,3,2 repeating)
    function automatic int grp_width(input int g);
        return ((g % 3) == 2) ? 2 : 3;
    endfunction

    // Idle edges after the last accept by which all carries have drained
    function automatic int drain_bound(input int lane_w);
        return grp_count(lane_w) + 2;
    endfunction

endpackage

// File: rtl/oc_lookahead_grp.sv
// Module: short full-lookahead adder group (combinational).
// Adds two W-bit slices plus a carry-in; W is small (2 or 3), so the carry
// terms flatten into one level of logic.
module oc_lookahead_grp #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    logic [W:0] c;

    // Generate/propagate carry terms, sum bits and group carry-out
    always_comb begin
        c[0] = cin;
        for (int i = 0; i < W; i++) begin
            c[i+1] = (a[i] & b[i]) | ((a[i] | b[i]) & c[i]);
        end
        s    = a ^ b ^ c[W-1:0];
        cout = c[W];
    end

endmodule

// File: rtl/oc_input_latch.sv
// Module: one-word input latch. Captures din when add_en is high, otherwise
// loads zero, so an idle cycle adds nothing. Clear/reset empty it.
module oc_input_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] data_q,
    output logic         vld_q
);

    // Capture the word (or zero) and its valid flag; clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= add_en ? din : '0;
            vld_q  <= add_en;
        end
    end

endmodule

// File: rtl/oc_ring_lane.sv
// Module: one ones-complement lane built as a ring of lookahead groups.
// Each group's carry-out is registered and feeds the next group's carry-in
// one clock later; the top group's carry wraps to the bottom group.
module oc_ring_lane
    import oc_accum_pkg::*;
#(
    parameter int LANE_W = 16,
    localparam int NGRP  = grp_count(LANE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [LANE_W-1:0] addend,
    output logic [LANE_W-1:0] sum_q,
    output logic [NGRP-1:0]   cy_q
);

    logic [LANE_W-1:0] nxt_sum;
    logic [NGRP-1:0]   nxt_cy;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LSB  = grp_lsb(g);
        localparam int GW   = grp_width(g);
        localparam int PREV = (g + NGRP - 1) % NGRP;

        oc_lookahead_grp #(.W(GW)) u_grp (
            .a    (sum_q[LSB +: GW]),
            .b    (addend[LSB +: GW]),
            .cin  (cy_q[PREV]),
            .s    (nxt_sum[LSB +: GW]),
            .cout (nxt_cy[g])
        );
    end

    // Register lane sum and the ring of group carries
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
            cy_q  <= '0;
        end else begin
            sum_q <= nxt_sum;
            cy_q  <= nxt_cy;
        end
    end

endmodule

// File: rtl/oc_ring_accum.sv
// Module: top of the two-lane ring-carry ones-complement accumulator.
// Assumes DATA_W is a multiple of LANE_W; lanes are fully independent.
module oc_ring_accum
    import oc_accum_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] sum_q,
    output logic              settled
);

    localparam int NLANE = DATA_W / LANE_W;
    localparam int NGRP  = grp_count(LANE_W);

    logic [DATA_W-1:0]     lat_data;
    logic                  lat_vld;
    logic [NLANE*NGRP-1:0] cy_all;

    oc_input_latch #(.W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .add_en (add_en),
        .din    (din),
        .data_q (lat_data),
        .vld_q  (lat_vld)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        oc_ring_lane #(.LANE_W(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .addend (lat_data[l*LANE_W +: LANE_W]),
            .sum_q  (sum_q[l*LANE_W +: LANE_W]),
            .cy_q   (cy_all[l*NGRP +: NGRP])
        );
    end

    // Final once nothing is latched and no carry is in flight
    assign settled = ~lat_vld & ~(|cy_all);

endmodule

// File: rtl/oc_ring_accum_chk.sv
// Module: assertion checker for oc_ring_accum, bound to every instance.
module oc_ring_accum_chk
    import oc_accum_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              add_en,
    input logic [DATA_W-1:0] sum_q,
    input logic              settled
);

    localparam int BOUND = drain_bound(LANE_W);

    logic [7:0] idle_cnt;

    // Count idle edges since the last accept, saturating at the bound
    always_ff @(posedge clk) begin
        if (!rst_n || clr || add_en) idle_cnt <= '0;
        else if (idle_cnt < 8'(BOUND)) idle_cnt <= idle_cnt + 8'd1;
    end

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == '0) && settled);

    // R6
    settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !clr) |=> $stable(sum_q));

    // R4
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !clr && !add_en) |=> settled);

    // R3
    accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> !settled);

    // R5
    drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= 8'(BOUND)) |-> settled);

endmodule

bind oc_ring_accum oc_ring_accum_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .add_en  (add_en),
    .sum_q   (sum_q),
    .settled (settled)
);

// File: tb/tb_oc_ring_accum.sv
module tb_oc_ring_accum;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        add_en = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] sum_q;
    logic        settled;

    int tests = 0;
    int fails = 0;
    int ref_lo = 0;
    int ref_hi = 0;
    int since_add = 0;
    logic [31:0] rng = 32'h1badcafe;

    oc_ring_accum dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(add_en),
        .din(din), .sum_q(sum_q), .settled(settled)
    );

    always #2.5 clk = ~clk;

    function automatic int oc_add(input int s, input int x);
        int t;
        t = s + x;
        return (t & 16'hFFFF) + (t >>> 16);
    endfunction

    // Behavioural reference: updated on the same edge the inputs apply
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            ref_lo = 0; ref_hi = 0; since_add = 0;
        end else if (add_en) begin
            ref_lo = oc_add(ref_lo, int'(din[15:0]));
            ref_hi = oc_add(ref_hi, int'(din[31:16]));
            since_add = 0;
        end else begin
            since_add = since_add + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && settled === 1'b1)
            check("R2 settled sum vs model", sum_q, {ref_hi[15:0], ref_lo[15:0]});
        if (rst_n && since_add == 8)
            check("R5 settled within bound", {31'd0, settled}, 32'd1);
    end

    task automatic drive(input logic a, input logic [31:0] d, input logic c);
        @(negedge clk);
        add_en = a; din = d; clr = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 32'hDEAD_BEEF, 1'b0);
    endtask

    function automatic logic [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Watchdog
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int acc;
        int f;
        logic [31:0] hold;
        // R8 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset sum", sum_q, 32'h0);
        check("R8 reset settled", {31'd0, settled}, 32'd1);
        rst_n = 1'b1;

        // R3 single word, R1 lanes split
        drive(1'b1, 32'h1234_5678, 1'b0);
        drive(1'b0, 32'h0, 1'b0);
        check("R3 pending after accept", {31'd0, settled}, 32'd0);
        idle(9);
        check("R1 R3 single word", sum_q, 32'h1234_5678);

        // R1 R2 overflow in low lane only, high lane must stay 0
        drive(1'b0, 32'h0, 1'b1);
        drive(1'b1, 32'h0000_FFFF, 1'b0);
        drive(1'b1, 32'h0000_0001, 1'b0);
        idle(10);
        check("R1 R2 wrap low lane, high lane untouched", sum_q, 32'h0000_0001);

        // R5 R2 full-ring carry chain in both lanes: 0xFFFF + 1
        drive(1'b0, 32'h0, 1'b1);
        drive(1'b1, 32'h8000_8000, 1'b0);
        drive(1'b1, 32'h7FFF_7FFF, 1'b0);
        idle(9);
        check("R2 reach all ones", sum_q, 32'hFFFF_FFFF);
        drive(1'b1, 32'h0001_0001, 1'b0);
        idle(10);
        check("R5 R2 ring chain result", sum_q, 32'h0001_0001);

        // R4 ignored data while add_en low
        hold = sum_q;
        idle(6);
        check("R4 idle data ignored", sum_q, hold);
        check("R4 still settled", {31'd0, settled}, 32'd1);

        // R7 clear with add_en in same cycle: word discarded
        drive(1'b1, 32'hAAAA_5555, 1'b1);
        drive(1'b0, 32'h0, 1'b0);
        check("R7 clear wins over add", sum_q, 32'h0);
        check("R7 settled after clear", {31'd0, settled}, 32'd1);

        // R3 R2 back-to-back burst vs Internet checksum
        acc = 0;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            w = nxt();
            acc += int'(w[15:0]) + int'(w[31:16]);
            drive(1'b1, w, 1'b0);
        end
        idle(10);
        while (acc > 16'hFFFF) acc = (acc & 16'hFFFF) + (acc >>> 16);
        f = int'(sum_q[15:0]) + int'(sum_q[31:16]);
        f = (f & 16'hFFFF) + (f >>> 16);
        f = (f & 16'hFFFF) + (f >>> 16);
        check("R3 R2 burst checksum", {16'h0, ~f[15:0]}, {16'h0, ~acc[15:0]});

        // R3 R4 gapped stream of all-ones-heavy words
        drive(1'b0, 32'h0, 1'b1);
        acc = 0;
        for (int i = 0; i < 200; i++) begin
            logic [31:0] w;
            logic a;
            w = (i % 3 == 0) ? 32'hFFFF_FFFF : nxt();
            a = (i % 4) != 3;
            if (a) acc += int'(w[15:0]) + int'(w[31:16]);
            drive(a, w, 1'b0);
        end
        idle(10);
        while (acc > 16'hFFFF) acc = (acc & 16'hFFFF) + (acc >>> 16);
        f = int'(sum_q[15:0]) + int'(sum_q[31:16]);
        f = (f & 16'hFFFF) + (f >>> 16);
        f = (f & 16'hFFFF) + (f >>> 16);
        check("R4 gapped stream checksum", {16'h0, ~f[15:0]}, {16'h0, ~acc[15:0]});

        // R8 reset mid-stream
        drive(1'b1, 32'h0F0F_F0F0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0; add_en = 1'b1; din = 32'h1111_1111;
        @(negedge clk);
        rst_n = 1'b1; add_en = 1'b0;
        check("R8 mid-stream reset", sum_q, 32'h0);
        idle(10);
        check("R8 stays clear", sum_q, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule